// File: doc/BRIEF.md
# In-Flight Call and Branch Limiter

This block sits at the in-order allocate stage of an out-of-order core. It caps how many speculative call instructions, and how many control-transfer instructions of any kind, may be in flight at once. Each cycle it sees one instruction at allocate, tagged as a call, a return, another branch (a jump), or a plain instruction. It keeps three occupancy counters: calls, returns, and all branches. Calls and returns also count as branches. Retirement can free several instructions in one cycle. A pipeline flush loads the exact survivor counts.

When admitting the presented instruction would break a budget, the block raises a stall. The front end holds that instruction, and everything younger waits behind it in program order. A compatibility mode, selected by a pin, changes two rules. It replaces the branch budget with the reorder-buffer depth. It also admits at most one call while two or more returns are outstanding.

Top module: `inflight_alloc_gate`

## Requirements
- R1: After reset all three occupancy outputs read zero and `alloc_stall` is low.
- R2: An admitted call raises `calls_inflight` by one. A call presented while `calls_inflight` equals `CALL_MAX` (default 15) is stalled.
- R3: An admitted call, return or jump raises `branches_inflight` by one. An admitted return raises `rets_inflight` by one. With `legacy_en` low, any call, return or jump presented while `branches_inflight` equals `BR_MAX` (default 48) is stalled.
- R4: With `legacy_en` low, whether a call is admitted does not depend on `rets_inflight`.
- R5: With `legacy_en` high, a call is stalled when `rets_inflight` is at least 2 and `calls_inflight` is at least 1. With fewer than 2 returns outstanding this rule does not stall it.
- R6: With `legacy_en` high, the branch budget is `ROB_DEPTH` (default 40) instead of `BR_MAX`.
- R7: A plain instruction (`alloc_valid` high, no type flag) is never stalled. A stalled instruction changes no counter.
- R8: `free_calls`, `free_rets` and `free_jumps` retire up to `RETIRE_W` instructions of each kind in one cycle. The calls counter drops by `free_calls`, the returns counter by `free_rets`, and the branch counter by their sum. No counter goes below zero.
- R9: In a cycle with `flush_valid` high, the counters load `keep_calls`, `keep_rets` and `keep_calls+keep_rets+keep_jumps` on the next edge. Retire counts and the presented instruction are ignored in that cycle.
- R10: `alloc_stall` is combinational from the registered counts. A free that brings a count below its limit releases the stall in the following cycle, not in the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_en | input | 1 | Selects the compatibility budget rules |
| alloc_valid | input | 1 | An instruction is presented at allocate |
| alloc_call | input | 1 | Presented instruction is a call |
| alloc_ret | input | 1 | Presented instruction is a return |
| alloc_jump | input | 1 | Presented instruction is another branch |
| free_calls | input | FW | Calls retiring this cycle |
| free_rets | input | FW | Returns retiring this cycle |
| free_jumps | input | FW | Other branches retiring this cycle |
| flush_valid | input | 1 | Flush; load survivor counts |
| keep_calls | input | CNT_W | Surviving calls after the flush |
| keep_rets | input | CNT_W | Surviving returns after the flush |
| keep_jumps | input | CNT_W | Surviving other branches after the flush |
| alloc_stall | output | 1 | Hold the presented instruction and all younger ones |
| calls_inflight | output | CNT_W | Calls in flight |
| rets_inflight | output | CNT_W | Returns in flight |
| branches_inflight | output | CNT_W | All branches in flight, calls and returns included |

## Verification
The assertions assume that at most one type flag is set with `alloc_valid`. They also assume that flush survivor counts never exceed what is actually outstanding: the surviving calls are no more than the calls in flight, and the survivor total fits within the active branch budget. The random phase draws `keep_calls` from zero up to the modelled call count and keeps the other survivors small, so a flush never loads a count above a budget. Retire counts are drawn freely, because the floor at zero is itself a requirement, and the scoreboard saturates in the same way.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
   localparam int NUM_CTR  = 3;
   localparam int IDX_CALL = 0;
   localparam int IDX_RET  = 1;
   localparam int IDX_ALL  = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ifg_counter.sv
module ifg_counter #(
   parameter int CNT_W = 6,
   parameter int DEC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [DEC_W-1:0] dec,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);
   localparam int SW = ((CNT_W > DEC_W) ? CNT_W : DEC_W) + 1;

   logic [SW-1:0]    sum_w;
   logic [SW-1:0]    dec_w;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      sum_w = SW'(cnt) + SW'(inc);
      dec_w = SW'(dec);
      if (load)                nxt = load_val;
      else if (dec_w >= sum_w) nxt = '0;
      else                     nxt = CNT_W'(sum_w - dec_w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   // R9: a flush loads the survivor count exactly
   p_flush_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

   // R8: an empty counter with no admission stays at zero whatever is freed
   p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !inc && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/ifg_gate.sv
module ifg_gate #(
   parameter int CNT_W     = 6,
   parameter int CALL_MAX  = 15,
   parameter int BR_MAX    = 48,
   parameter int ROB_DEPTH = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             legacy_en,
   input  logic             alloc_valid,
   input  logic             is_call,
   input  logic             is_ret,
   input  logic             is_jump,
   input  logic [CNT_W-1:0] call_cnt,
   input  logic [CNT_W-1:0] ret_cnt,
   input  logic [CNT_W-1:0] br_cnt,
   output logic             stall
);
   localparam logic [CNT_W-1:0] CALL_LIM = CNT_W'(CALL_MAX);
   localparam logic [CNT_W-1:0] BR_STD   = CNT_W'(BR_MAX);
   localparam logic [CNT_W-1:0] BR_LEG   = CNT_W'(ROB_DEPTH);
   localparam logic [CNT_W-1:0] RET_TRIP = CNT_W'(2);

   logic             any_br;
   logic [CNT_W-1:0] br_lim;
   logic             call_full;
   logic             br_full;
   logic             legacy_hold;

   always_comb begin
      any_br      = is_call | is_ret | is_jump;
      br_lim      = legacy_en ? BR_LEG : BR_STD;
      call_full   = is_call && (call_cnt >= CALL_LIM);
      br_full     = any_br && (br_cnt >= br_lim);
      legacy_hold = legacy_en && is_call && (ret_cnt >= RET_TRIP) && (call_cnt != '0);
      stall       = alloc_valid && (call_full || br_full || legacy_hold);
   end

   // R7: at most one type flag per instruction (input assumption)
   p_type_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> $onehot0({is_call, is_ret, is_jump}));

   p_call_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && is_call && call_cnt == CALL_LIM) |-> stall);

   p_branch_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !legacy_en && (is_call || is_ret || is_jump) && br_cnt >= BR_STD) |-> stall);

   p_legacy_one_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && legacy_en && is_call && ret_cnt >= RET_TRIP && call_cnt != '0) |-> stall);

   p_rob_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && legacy_en && is_jump && br_cnt >= BR_LEG) |-> stall);

   p_plain_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_call && !is_ret && !is_jump) |-> !stall);
endmodule

// File: rtl/inflight_alloc_gate.sv
module inflight_alloc_gate #(
   parameter  int CALL_MAX  = 15,
   parameter  int BR_MAX    = 48,
   parameter  int ROB_DEPTH = 40,
   parameter  int RETIRE_W  = 4,
   localparam int LIM_TOP   = (BR_MAX > ROB_DEPTH) ? BR_MAX : ROB_DEPTH,
   localparam int CNT_W     = $clog2(LIM_TOP + 1),
   localparam int FW        = $clog2(RETIRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             legacy_en,
   input  logic             alloc_valid,
   input  logic             alloc_call,
   input  logic             alloc_ret,
   input  logic             alloc_jump,
   input  logic [FW-1:0]    free_calls,
   input  logic [FW-1:0]    free_rets,
   input  logic [FW-1:0]    free_jumps,
   input  logic             flush_valid,
   input  logic [CNT_W-1:0] keep_calls,
   input  logic [CNT_W-1:0] keep_rets,
   input  logic [CNT_W-1:0] keep_jumps,
   output logic             alloc_stall,
   output logic [CNT_W-1:0] calls_inflight,
   output logic [CNT_W-1:0] rets_inflight,
   output logic [CNT_W-1:0] branches_inflight
);
   import ifg_pkg::*;

   localparam int DEC_W = FW + 2;

   if (CALL_MAX < 13 || CALL_MAX > 19) begin : g_bad_call
      $error("CALL_MAX must lie in 13..19");
   end
   if (BR_MAX < CALL_MAX || ROB_DEPTH < CALL_MAX) begin : g_bad_br
      $error("branch budgets must not be below the call budget");
   end
   if (RETIRE_W < 1) begin : g_bad_rw
      $error("RETIRE_W must be at least 1");
   end

   logic             admit;
   logic             inc_v [NUM_CTR];
   logic [DEC_W-1:0] dec_v [NUM_CTR];
   logic [CNT_W-1:0] ld_v  [NUM_CTR];
   logic [CNT_W-1:0] cnt_v [NUM_CTR];

   ifg_gate #(
      .CNT_W(CNT_W), .CALL_MAX(CALL_MAX), .BR_MAX(BR_MAX), .ROB_DEPTH(ROB_DEPTH)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en),
      .alloc_valid(alloc_valid), .is_call(alloc_call), .is_ret(alloc_ret),
      .is_jump(alloc_jump), .call_cnt(cnt_v[IDX_CALL]), .ret_cnt(cnt_v[IDX_RET]),
      .br_cnt(cnt_v[IDX_ALL]), .stall(alloc_stall)
   );

   always_comb begin
      admit           = alloc_valid && !alloc_stall && !flush_valid;
      inc_v[IDX_CALL] = admit && alloc_call;
      inc_v[IDX_RET]  = admit && alloc_ret;
      inc_v[IDX_ALL]  = admit && (alloc_call || alloc_ret || alloc_jump);
      dec_v[IDX_CALL] = DEC_W'(free_calls);
      dec_v[IDX_RET]  = DEC_W'(free_rets);
      dec_v[IDX_ALL]  = DEC_W'(free_calls) + DEC_W'(free_rets) + DEC_W'(free_jumps);
      ld_v[IDX_CALL]  = keep_calls;
      ld_v[IDX_RET]   = keep_rets;
      ld_v[IDX_ALL]   = keep_calls + keep_rets + keep_jumps;
   end

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      ifg_counter #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_v[k]), .dec(dec_v[k]),
         .load(flush_valid), .load_val(ld_v[k]), .cnt(cnt_v[k])
      );
   end

   assign calls_inflight    = cnt_v[IDX_CALL];
   assign rets_inflight     = cnt_v[IDX_RET];
   assign branches_inflight = cnt_v[IDX_ALL];

   // R2: the call budget is never exceeded
   p_call_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      calls_inflight <= CNT_W'(CALL_MAX));

   // R7: a held instruction with nothing freed leaves all counts unchanged
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_stall && !flush_valid && free_calls == '0 && free_rets == '0 && free_jumps == '0)
      |=> ($stable(calls_inflight) && $stable(rets_inflight) && $stable(branches_inflight)));
endmodule

// File: tb/sim_inflight_alloc_gate.sv
module sim_inflight_alloc_gate;
   typedef struct packed {
      logic [2:0] kind;
      logic [2:0] rc;
      logic [2:0] rr;
      logic       fl;
      logic       xs;
      logic [5:0] xc;
      logic [5:0] xb;
   } vec_t;

   // kind: 0 idle, 1 call, 2 return, 3 jump, 4 plain
   localparam vec_t TV [8] = '{
      '{3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 6'd1, 6'd1},
      '{3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 6'd2, 6'd2},
      '{3'd2, 3'd0, 3'd0, 1'b0, 1'b0, 6'd2, 6'd3},
      '{3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 6'd2, 6'd4},
      '{3'd0, 3'd1, 3'd1, 1'b0, 1'b0, 6'd1, 6'd2},
      '{3'd0, 3'd3, 3'd0, 1'b0, 1'b0, 6'd0, 6'd0},
      '{3'd1, 3'd0, 3'd0, 1'b0, 1'b0, 6'd1, 6'd1},
      '{3'd1, 3'd0, 3'd0, 1'b1, 1'b0, 6'd0, 6'd0}
   };

   logic clk = 1'b0;
   logic rst_n, legacy_en, alloc_valid, alloc_call, alloc_ret, alloc_jump, flush_valid;
   logic [2:0] free_calls, free_rets, free_jumps;
   logic [5:0] keep_calls, keep_rets, keep_jumps;
   logic       alloc_stall;
   logic [5:0] calls_inflight, rets_inflight, branches_inflight;

   int errors = 0, checks = 0, last_stall = 0;
   int mc = 0, mr = 0, mb = 0, mleg = 0;
   bit done = 0;

   always #4 clk = ~clk;

   inflight_alloc_gate u0 (
      .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .alloc_valid(alloc_valid),
      .alloc_call(alloc_call), .alloc_ret(alloc_ret), .alloc_jump(alloc_jump),
      .free_calls(free_calls), .free_rets(free_rets), .free_jumps(free_jumps),
      .flush_valid(flush_valid), .keep_calls(keep_calls), .keep_rets(keep_rets),
      .keep_jumps(keep_jumps), .alloc_stall(alloc_stall), .calls_inflight(calls_inflight),
      .rets_inflight(rets_inflight), .branches_inflight(branches_inflight)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_mode(input int leg);
      legacy_en = (leg != 0);
      mleg = leg;
   endtask

   task automatic cycle(input int kind, input int rc, input int rr, input int rj,
                        input int fl, input int kc, input int kr, input int kj,
                        input string tag);
      int es, blim, adm;
      bit bc, anyb;
      alloc_valid = (kind != 0);
      alloc_call  = (kind == 1);
      alloc_ret   = (kind == 2);
      alloc_jump  = (kind == 3);
      free_calls  = 3'(rc);
      free_rets   = 3'(rr);
      free_jumps  = 3'(rj);
      flush_valid = (fl != 0);
      keep_calls  = 6'(kc);
      keep_rets   = 6'(kr);
      keep_jumps  = 6'(kj);
      #1;
      bc   = (kind == 1);
      anyb = (kind >= 1 && kind <= 3);
      blim = mleg ? 40 : 48;
      es = (kind != 0) && ((bc && mc >= 15) || (anyb && mb >= blim) ||
                           (mleg != 0 && bc && mr >= 2 && mc >= 1));
      last_stall = int'(alloc_stall);
      chk(tag, last_stall, es);
      @(posedge clk);
      if (fl != 0) begin
         mc = kc; mr = kr; mb = kc + kr + kj;
      end else begin
         adm = (kind != 0 && es == 0) ? 1 : 0;
         mc = mc + ((adm != 0 && bc) ? 1 : 0) - rc;
         if (mc < 0) mc = 0;
         mr = mr + ((adm != 0 && kind == 2) ? 1 : 0) - rr;
         if (mr < 0) mr = 0;
         mb = mb + ((adm != 0 && anyb) ? 1 : 0) - (rc + rr + rj);
         if (mb < 0) mb = 0;
      end
      @(negedge clk);
      chk(tag, int'(calls_inflight), mc);
      chk(tag, int'(rets_inflight), mr);
      chk(tag, int'(branches_inflight), mb);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      set_mode(0);
      alloc_valid = 0; alloc_call = 0; alloc_ret = 0; alloc_jump = 0;
      free_calls = 0; free_rets = 0; free_jumps = 0;
      flush_valid = 0; keep_calls = 0; keep_rets = 0; keep_jumps = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", int'(alloc_stall), 0);
      chk("R1", int'(calls_inflight), 0);
      chk("R1", int'(rets_inflight), 0);
      chk("R1", int'(branches_inflight), 0);

      // Table walk: R3 counting, R8 saturation, R9 flush
      for (int i = 0; i < 8; i++) begin
         cycle(int'(TV[i].kind), int'(TV[i].rc), int'(TV[i].rr), 0,
               int'(TV[i].fl), 0, 0, 0, "R3");
         chk("R3", last_stall, int'(TV[i].xs));
         chk("R3", int'(calls_inflight), int'(TV[i].xc));
         chk("R3", int'(branches_inflight), int'(TV[i].xb));
      end

      // R2: fill the call budget
      for (int i = 0; i < 15; i++) cycle(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      chk("R2", int'(calls_inflight), 15);
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      chk("R2", last_stall, 1);
      chk("R7", int'(calls_inflight), 15);
      cycle(4, 0, 0, 0, 0, 0, 0, 0, "R7");
      chk("R7", last_stall, 0);
      // R10: a free in the stall cycle does not release it until the next cycle
      cycle(1, 1, 0, 0, 0, 0, 0, 0, "R10");
      chk("R10", last_stall, 1);
      chk("R10", int'(calls_inflight), 14);
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R10");
      chk("R10", last_stall, 0);
      chk("R10", int'(calls_inflight), 15);

      // R4: many returns do not block calls in default mode
      cycle(0, 0, 0, 0, 1, 14, 6, 0, "R4");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R4");
      chk("R4", last_stall, 0);
      chk("R4", int'(calls_inflight), 15);

      // R3: branch budget of 48
      cycle(0, 0, 0, 0, 1, 0, 0, 48, "R3");
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R3");
      chk("R3", last_stall, 1);
      cycle(2, 0, 0, 0, 0, 0, 0, 0, "R3");
      chk("R3", last_stall, 1);
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R3");
      chk("R3", last_stall, 1);
      cycle(0, 0, 0, 0, 1, 0, 0, 47, "R3");
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R3");
      chk("R3", last_stall, 0);
      chk("R3", int'(branches_inflight), 48);

      // R9: flush overrides retire and the presented instruction
      cycle(1, 1, 0, 0, 1, 2, 0, 0, "R9");
      chk("R9", int'(calls_inflight), 2);
      chk("R9", int'(branches_inflight), 2);

      // R8: multi-retire and floor at zero
      cycle(0, 4, 0, 0, 0, 0, 0, 0, "R8");
      chk("R8", int'(calls_inflight), 0);
      chk("R8", int'(branches_inflight), 0);
      cycle(0, 0, 0, 0, 1, 3, 2, 3, "R8");
      cycle(0, 2, 1, 3, 0, 0, 0, 0, "R8");
      chk("R8", int'(calls_inflight), 1);
      chk("R8", int'(rets_inflight), 1);
      chk("R8", int'(branches_inflight), 2);

      // R5: legacy one-call rule
      set_mode(1);
      cycle(0, 0, 0, 0, 1, 1, 2, 0, "R5");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R5");
      chk("R5", last_stall, 1);
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R5");
      chk("R5", last_stall, 0);
      cycle(0, 0, 0, 0, 1, 0, 2, 0, "R5");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R5");
      chk("R5", last_stall, 0);
      chk("R5", int'(calls_inflight), 1);
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R5");
      chk("R5", last_stall, 1);
      cycle(0, 0, 0, 0, 1, 3, 1, 0, "R5");
      cycle(1, 0, 0, 0, 0, 0, 0, 0, "R5");
      chk("R5", last_stall, 0);

      // R6: legacy branch budget is the reorder-buffer depth
      cycle(0, 0, 0, 0, 1, 1, 2, 37, "R6");
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R6");
      chk("R6", last_stall, 1);
      cycle(0, 0, 0, 0, 1, 1, 2, 36, "R6");
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R6");
      chk("R6", last_stall, 0);
      chk("R6", int'(branches_inflight), 40);
      set_mode(0);
      cycle(3, 0, 0, 0, 0, 0, 0, 0, "R6");
      chk("R6", last_stall, 0);

      // Scoreboard-checked random traffic in both modes
      for (int ph = 0; ph < 2; ph++) begin
         cycle(0, 0, 0, 0, 1, 0, 0, 0, "R9");
         set_mode(ph);
         for (int n = 0; n < 1500; n++) begin
            int kind, rc, rr, rj, fl, kc, kr, kj;
            kind = int'($urandom % 5);
            rc = 0; rr = 0; rj = 0; kc = 0; kr = 0; kj = 0;
            if ($urandom % 3 == 0) begin
               rc = int'($urandom % 5);
               rr = int'($urandom % 5);
               rj = int'($urandom % 5);
            end
            fl = ($urandom % 16 == 0) ? 1 : 0;
            if (fl != 0) begin
               kc = int'($urandom % (mc + 1));
               kr = int'($urandom % 3);
               kj = int'($urandom % 8);
            end
            cycle(kind, rc, rr, rj, fl, kc, kr, kj, (ph == 0) ? "R7" : "R5");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule